// File: doc/BRIEF.md
# Serial Flash Block Read Controller

This block is the host side of a serial flash read path. A one-cycle request carries a 24-bit start address, a byte count and a select between the plain and the fast read command. The controller pulls chip select low, sends the command frame on SI with SCK derived from the system clock, then collects the requested number of bytes from SO. Each received byte is presented for one cycle with a valid strobe. The flash advances its own address pointer, so any count is served within one chip-select window. Address rollover at the top of the array is left to the device.

The frame is an opcode followed by the address, most significant bit first. For the fast command one all-zero dummy byte follows the address. The plain command runs SCK at a slower rate that is derived from the parameters, so the rate limit of the plain command cannot be exceeded. SCK idles low (mode 0). SI changes after falling edges and SO is captured on rising edges. Between transactions chip select stays high for a configurable minimum number of cycles. The block reports busy for the whole transaction, including this recovery time.

Top module: `flash_read_ctrl`

## Requirements
- R1: With `req_fast_i` low, the frame on SI is opcode 0x03 followed by the 24 address bits, all MSB first. Data capture starts after the 32nd SCK rising edge.
- R2: With `req_fast_i` high, the frame is opcode 0x0B, then the 24 address bits, then 8 dummy bits, all MSB first. Data capture starts only after the 40th SCK rising edge.
- R3: Chip select stays low from the start of the frame until the last requested byte has been captured. Exactly `req_len_i` bytes are delivered through `rd_valid_o`. Chip select then rises, and `done_o` pulses in the same cycle.
- R4: Each byte is assembled MSB first from eight consecutive SO bits. Successive bytes come from consecutive flash addresses, including across the rollover from 0xFFFFFF to 0x000000.
- R5: The SCK half period is `HALF_FAST` system cycles for the fast command. For the plain command it is the larger of `HALF_PLAIN` and 2*`HALF_FAST`.
- R6: SCK is low whenever chip select is high (mode 0). While chip select is low, SI changes only in cycles where SCK is low.
- R7: After chip select rises it stays high for at least `CS_GAP` system cycles, and `busy_o` stays high until that time has elapsed.
- R8: `busy_o` is high in the cycle after an accepted non-zero request. A request presented while `busy_o` is high is ignored and starts no chip-select window.
- R9: A request with `req_len_i` = 0 while idle pulses `done_o` in the next cycle. It does not assert chip select or `busy_o`.
- R10: SI is 0 during the dummy byte and during the whole data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, taken only while idle |
| req_addr_i | input | 24 | Start address in flash |
| req_len_i | input | LEN_W | Number of bytes to read |
| req_fast_i | input | 1 | 1 selects the fast command with dummy byte |
| busy_o | output | 1 | Transaction in progress, including chip-select recovery |
| done_o | output | 1 | One-cycle completion pulse |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_data_o` |
| rd_data_o | output | 8 | Received byte |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_si_o | output | 1 | Serial data to flash |
| spi_so_i | input | 1 | Serial data from flash |

## Verification
Two events can meet in one cycle: the end of a transfer, when chip select rises and `done_o` pulses, and a new request from the host. The bench waits for the rising edge of chip select and raises `req_i` in that very cycle. A second request is also issued in the middle of a transfer. The bench then judges that the number of chip-select windows did not grow, that the byte count and data belong only to the first request, and that the next request accepted after `busy_o` falls sees the full recovery gap.

// File: rtl/flash_read_pkg.sv
package flash_read_pkg;
  localparam int unsigned ADDR_W  = 24;
  localparam int unsigned FRAME_W = 40;
  localparam logic [7:0]  OP_PLAIN = 8'h03;
  localparam logic [7:0]  OP_FAST  = 8'h0B;
  localparam logic [5:0]  BITS_PLAIN = 6'd32;
  localparam logic [5:0]  BITS_FAST  = 6'd40;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_GAP
  } fr_state_e;
endpackage

// File: rtl/frc_tick_gen.sv
module frc_tick_gen #(
  parameter int unsigned HALF_FAST  = 2,
  parameter int unsigned HALF_PLAIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fast_i,
  output logic tick_o
);
  // plain rate never exceeds half the fast rate
  localparam int unsigned HALF_PLAIN_EFF =
    (HALF_PLAIN < 2 * HALF_FAST) ? 2 * HALF_FAST : HALF_PLAIN;
  localparam int unsigned CW = $clog2(HALF_PLAIN_EFF + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = fast_i ? CW'(HALF_FAST - 1) : CW'(HALF_PLAIN_EFF - 1);
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $stable(fast_i) |-> cnt_q <= lim);
endmodule

// File: rtl/frc_tx_shift.sv
module frc_tx_shift #(
  parameter int unsigned W = 40
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] frame_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (load_i)   q <= frame_i;
    else if (shift_i)  q <= {q[W-2:0], 1'b0};
  end

  assign bit_o = q[W-1];
endmodule

// File: rtl/frc_rx_shift.sv
module frc_rx_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] q;

  assign word_o = {q[W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (shift_i) q <= word_o;
  end
endmodule

// File: rtl/flash_read_ctrl.sv
module flash_read_ctrl
  import flash_read_pkg::*;
#(
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned HALF_FAST  = 2,
  parameter int unsigned HALF_PLAIN = 4,
  parameter int unsigned CS_GAP     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [23:0]       req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_fast_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              spi_cs_no,
  output logic              spi_sck_o,
  output logic              spi_si_o,
  input  logic              spi_so_i
);
  localparam int unsigned GAP_N = (CS_GAP < 1) ? 1 : CS_GAP;
  localparam int unsigned GAP_W = $clog2(GAP_N + 1);

  fr_state_e         state_q;
  logic              fast_q;
  logic [LEN_W-1:0]  left_q;
  logic [5:0]        bit_q;
  logic [2:0]        bcnt_q;
  logic              last_q;
  logic              sck_q;
  logic              cs_nq;
  logic [GAP_W-1:0]  gap_q;
  logic              valid_q;
  logic [7:0]        data_q;
  logic              done_q;

  logic              accept, start, active, tick, rise, fall;
  logic [5:0]        frame_bits;
  logic [FRAME_W-1:0] frame;
  logic [7:0]        rx_byte;

  assign accept     = req_i && (state_q == ST_IDLE);
  assign start      = accept && (req_len_i != '0);
  assign active     = (state_q == ST_CMD) || (state_q == ST_DATA);
  assign rise       = tick && !sck_q;
  assign fall       = tick && sck_q;
  assign frame_bits = fast_q ? BITS_FAST : BITS_PLAIN;
  assign frame      = {(req_fast_i ? OP_FAST : OP_PLAIN), req_addr_i, 8'h00};

  frc_tick_gen #(.HALF_FAST(HALF_FAST), .HALF_PLAIN(HALF_PLAIN)) i_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(active), .fast_i(fast_q), .tick_o(tick)
  );

  frc_tx_shift #(.W(FRAME_W)) i_tx (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(start), .frame_i(frame),
    .shift_i(fall), .bit_o(spi_si_o)
  );

  frc_rx_shift #(.W(8)) i_rx (
    .clk_i (clk_i), .rst_ni(rst_ni), .shift_i(rise && (state_q == ST_DATA)),
    .bit_i(spi_so_i), .word_o(rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fast_q  <= 1'b0;
      left_q  <= '0;
      bit_q   <= '0;
      bcnt_q  <= '0;
      last_q  <= 1'b0;
      sck_q   <= 1'b0;
      cs_nq   <= 1'b1;
      gap_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (req_len_i == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_CMD;
              cs_nq   <= 1'b0;
              fast_q  <= req_fast_i;
              left_q  <= req_len_i;
              bit_q   <= '0;
              bcnt_q  <= '0;
              last_q  <= 1'b0;
            end
          end
        end
        ST_CMD: begin
          if (rise) begin
            sck_q <= 1'b1;
            bit_q <= bit_q + 1'b1;
          end else if (fall) begin
            sck_q <= 1'b0;
            if (bit_q == frame_bits) state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (rise) begin
            sck_q  <= 1'b1;
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == 3'd7) begin
              valid_q <= 1'b1;
              data_q  <= rx_byte;
              left_q  <= left_q - 1'b1;
              if (left_q == LEN_W'(1)) last_q <= 1'b1;
            end
          end else if (fall) begin
            sck_q <= 1'b0;
            if (last_q) begin
              cs_nq   <= 1'b1;
              done_q  <= 1'b1;
              gap_q   <= '0;
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(GAP_N - 1)) state_q <= ST_IDLE;
          else                            gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign rd_valid_o = valid_q;
  assign rd_data_o  = data_q;
  assign spi_cs_no  = cs_nq;
  assign spi_sck_o  = sck_q;

  p_idle_sck_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  p_si_on_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(spi_si_o) && !spi_cs_no && $past(!spi_cs_no)) |-> !spi_sck_o);
  p_si_zero_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> !spi_si_o);
  p_zero_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && req_len_i == '0) |=> (done_o && spi_cs_no && !busy_o));
  p_busy_on_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && req_len_i != '0) |=> (busy_o && !spi_cs_no));
  p_cs_low_when_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_cs_no) |-> busy_o);
  p_valid_in_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !spi_cs_no);
  p_done_with_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |-> (done_o && busy_o));
  p_gap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |=> (spi_cs_no && busy_o));
endmodule

// File: tb/test_flash_read_ctrl.sv
`timescale 1ns/1ps
module test_flash_read_ctrl;
  localparam int LEN_W = 16;
  localparam int HALF_FAST = 2;
  localparam int HALF_PLAIN = 4;
  localparam int CS_GAP = 6;
  localparam int TCLK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_fast = 1'b0;
  logic busy, done, rd_valid, cs_n, sck, si;
  logic [7:0] rd_data;
  logic so = 1'b0;

  always #(TCLK/2) clk = ~clk;

  flash_read_ctrl #(.LEN_W(LEN_W), .HALF_FAST(HALF_FAST), .HALF_PLAIN(HALF_PLAIN),
                    .CS_GAP(CS_GAP)) i_flash_read_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr),
    .req_len_i(req_len), .req_fast_i(req_fast), .busy_o(busy), .done_o(done),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .spi_cs_no(cs_n),
    .spi_sck_o(sck), .spi_si_o(si), .spi_so_i(so)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] mem(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  // flash model
  logic [39:0] m_sh;
  int m_bits, m_pos, m_si_bad, m_frames;
  bit m_data;
  logic [7:0] m_op, m_dummy;
  logic [23:0] m_addr, m_ptr;

  always @(negedge cs_n) begin
    m_bits = 0; m_data = 0; m_sh = '0; m_frames++;
  end
  always @(posedge sck) if (!cs_n) begin
    if (!m_data) begin
      m_sh = {m_sh[38:0], si};
      m_bits++;
      if (m_bits == 32 && m_sh[31:24] == 8'h03) begin
        m_op = 8'h03; m_addr = m_sh[23:0]; m_ptr = m_addr; m_data = 1; m_pos = 7;
      end else if (m_bits == 40 && m_sh[39:32] == 8'h0B) begin
        m_op = 8'h0B; m_addr = m_sh[31:8]; m_dummy = m_sh[7:0];
        m_ptr = m_addr; m_data = 1; m_pos = 7;
      end
    end else if (si) m_si_bad++;
  end
  always @(negedge sck) if (!cs_n && m_data) begin
    so = mem(m_ptr)[m_pos];
    if (m_pos == 0) begin m_pos = 7; m_ptr++; end
    else m_pos--;
  end

  // monitors
  logic [7:0] rx_buf [0:63];
  int rx_n, done_n, idle_bad;
  longint last_pos, per_min, per_max, t_rise, gap_min;

  always @(negedge clk) begin
    if (rd_valid) begin
      if (rx_n < 64) rx_buf[rx_n] = rd_data;
      rx_n++;
    end
    if (done) done_n++;
    if (cs_n && sck) idle_bad++;
  end
  always @(negedge cs_n) begin
    last_pos = -1;
    if (t_rise >= 0 && ($time - t_rise) < gap_min) gap_min = $time - t_rise;
  end
  always @(posedge cs_n) t_rise = $time;
  always @(posedge sck) if (!cs_n) begin
    if (last_pos >= 0) begin
      if ($time - last_pos < per_min) per_min = $time - last_pos;
      if ($time - last_pos > per_max) per_max = $time - last_pos;
    end
    last_pos = $time;
  end

  task automatic clear_mon();
    rx_n = 0; per_min = 1_000_000; per_max = 0; m_frames = 0; done_n = 0;
  endtask

  task automatic issue(input logic [23:0] a, input int n, input bit f);
    while (busy) @(negedge clk);
    req = 1'b1; req_addr = a; req_len = LEN_W'(n); req_fast = f;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (done_n == 0 && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic check_read(input logic [23:0] a, input int n, input bit f, input string rq);
    chk(m_frames == 1, "R3 single window", m_frames, 1);
    chk(m_op == (f ? 8'h0B : 8'h03), f ? "R2 opcode" : "R1 opcode", m_op, f ? 8'h0B : 8'h03);
    chk(m_addr == a, f ? "R2 address" : "R1 address", m_addr, a);
    if (f) chk(m_dummy == 8'h00, "R10 dummy zero", m_dummy, 0);
    chk(rx_n == n, "R3 byte count", rx_n, n);
    for (int i = 0; i < n && i < 64; i++)
      chk(rx_buf[i] == mem(a + 24'(i)), rq, rx_buf[i], mem(a + 24'(i)));
    chk(per_min == per_max && per_max == (f ? 2*HALF_FAST*TCLK : 2*HALF_PLAIN*TCLK),
        "R5 SCK period", per_max, f ? 2*HALF_FAST*TCLK : 2*HALF_PLAIN*TCLK);
    chk(cs_n == 1'b1, "R3 cs high after end", cs_n, 1);
  endtask

  task automatic t_reset();
    chk(cs_n && !sck && !busy && !rd_valid && !done, "R6 reset idle",
        {cs_n, sck, busy, rd_valid, done}, 5'b10000);
  endtask

  task automatic t_plain();
    clear_mon();
    issue(24'h012345, 4, 1'b0);
    chk(busy && !cs_n, "R8 busy after request", {busy, cs_n}, 2'b10);
    wait_done();
    check_read(24'h012345, 4, 1'b0, "R1 R4 plain data");
  endtask

  task automatic t_fast();
    clear_mon();
    issue(24'hABCDEF, 5, 1'b1);
    wait_done();
    check_read(24'hABCDEF, 5, 1'b1, "R2 R4 fast data");
  endtask

  task automatic t_wrap();
    clear_mon();
    issue(24'hFFFFFE, 4, 1'b1);
    wait_done();
    check_read(24'hFFFFFE, 4, 1'b1, "R4 rollover data");
  endtask

  task automatic t_zero();
    clear_mon();
    while (busy) @(negedge clk);
    req = 1'b1; req_addr = 24'h000100; req_len = '0; req_fast = 1'b0;
    @(negedge clk);
    req = 1'b0;
    chk(done && !busy && cs_n, "R9 zero length", {done, busy, cs_n}, 3'b101);
    repeat (20) @(negedge clk);
    chk(m_frames == 0 && rx_n == 0, "R9 no window", m_frames, 0);
  endtask

  task automatic t_collide();
    clear_mon();
    issue(24'h000040, 3, 1'b0);
    repeat (30) @(negedge clk);
    req = 1'b1; req_addr = 24'h777777; req_len = 16'd9; req_fast = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(posedge cs_n);
    @(negedge clk);
    req = 1'b1; req_addr = 24'h555555; req_len = 16'd2; req_fast = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (60) @(negedge clk);
    check_read(24'h000040, 3, 1'b0, "R8 first request data");
    chk(!busy, "R8 idle after ignored requests", busy, 0);
  endtask

  task automatic t_gap();
    gap_min = 1_000_000;
    clear_mon();
    issue(24'h100000, 2, 1'b1);
    wait_done();
    clear_mon();
    chk(busy && cs_n, "R7 busy during recovery", {busy, cs_n}, 2'b11);
    issue(24'h200000, 2, 1'b1);
    wait_done();
    check_read(24'h200000, 2, 1'b1, "R7 second read data");
    chk(gap_min >= CS_GAP*TCLK, "R7 cs high gap", gap_min, CS_GAP*TCLK);
  endtask

  initial begin
    m_frames = 0; m_si_bad = 0; idle_bad = 0; t_rise = -1; gap_min = 1_000_000;
    last_pos = -1; rx_n = 0; done_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_fast();
    t_wrap();
    t_zero();
    t_collide();
    t_gap();
    repeat (10) @(negedge clk);
    chk(m_si_bad == 0, "R10 SI zero in data", m_si_bad, 0);
    chk(idle_bad == 0, "R6 SCK low while deselected", idle_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule